// File: doc/BRIEF.md
# Snapshot capture control register

This block is a single 64-bit control and status register that lets software start a snapshot of the performance counters and then poll for the result. A register write that sets the request bit while the block is idle sends a one-cycle request pulse to a separate counter-snapshot engine. From that point the same bit reads back as a busy flag.

When the engine reports that it has finished, the busy flag drops. A second, read-only bit then records whether the engine actually captured the counters or failed to. The counter storage, the snapshot engine and all privilege checks sit outside this block. The block only holds the two status bits, produces the request pulse and returns the read word.

The busy flag sits at bit 0 and the no-capture flag at bit 32. Both positions are parameters. Read data is combinational by default, and a parameter selects a registered read path with one cycle of latency.

Top module: `snap_ctl_reg`

## Requirements
- R1: After reset the read word has bit 0 (busy) at 0 and bit 32 (no-capture) at 1, every other bit reads 0, and cap_req is 0.
- R2: A write whose data has bit 0 set, made while busy is 0, sets busy at that clock edge. The same edge raises cap_req, which stays high for exactly one cycle.
- R3: A write whose data has bit 0 clear changes neither busy nor no-capture, and no request pulse is produced.
- R4: A write with bit 0 set while busy is 1 is ignored. No second pulse is sent and busy stays 1. This also holds when cap_done arrives in the same cycle as the write, in which case the block ends up idle.
- R5: When cap_done is high while busy is 1, busy clears at the next edge and no-capture is loaded from cap_fail (1 = counters not captured, 0 = captured).
- R6: cap_done while busy is 0 is ignored, and no-capture keeps its value.
- R7: Bits other than 0 and 32 always read 0, and writes to them have no effect. Software writes to bit 32 have no effect.
- R8: With the default zero read latency, rd_data shows the register word during a cycle in which rd_en is high and shows 0 when rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 64 | Read data |
| cap_req | output | 1 | One-cycle capture request to the snapshot engine |
| cap_done | input | 1 | Capture finished indication from the engine |
| cap_fail | input | 1 | Qualifies cap_done: 1 means the counters were not captured |

## Verification
The block is driven with random mixes of writes (bit 0 set or clear, with random upper bits including bit 32), done pulses with random fail values, and reads with the strobe on or off. This separates a write that triggers from one that is ignored because the block is busy or because bit 0 is clear. Directed cases line up a done pulse with a write while busy, send a done pulse while idle, and write all-ones. These show whether the completion event takes priority over a new request, and whether a stray done can corrupt the no-capture flag.

// File: rtl/snap_pkg.sv
package snap_pkg;
   // Two architectural state bits of the snapshot register
   typedef struct packed {
      logic busy;
      logic nocap;
   } snap_state_t;

   localparam snap_state_t SNAP_RESET = '{busy: 1'b0, nocap: 1'b1};
endpackage

// File: rtl/snap_req_ctl.sv
module snap_req_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_wr,
   input  logic cap_done,
   output logic busy_q,
   output logic req_q
);
   logic start;
   assign start = trig_wr && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= snap_pkg::SNAP_RESET.busy;
         req_q  <= 1'b0;
      end else begin
         req_q <= start;
         if (busy_q && cap_done) busy_q <= 1'b0;
         else if (start)         busy_q <= 1'b1;
      end
   end
endmodule

// File: rtl/snap_status.sv
module snap_status (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_q,
   input  logic cap_done,
   input  logic cap_fail,
   output logic nocap_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                nocap_q <= snap_pkg::SNAP_RESET.nocap;
      else if (busy_q && cap_done) nocap_q <= cap_fail;
   end
endmodule

// File: rtl/snap_rd_mux.sv
module snap_rd_mux #(
   parameter int DATA_W    = 64,
   parameter int REQ_BIT   = 0,
   parameter int NOCAP_BIT = 32,
   parameter int RD_LAT    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  snap_pkg::snap_state_t st,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] word;

   always_comb begin
      word            = '0;
      word[REQ_BIT]   = st.busy;
      word[NOCAP_BIT] = st.nocap;
   end

   generate
      if (RD_LAT == 0) begin : g_comb
         assign rd_data = rd_en ? word : '0;
      end else begin : g_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_en) rd_q <= word;
            else            rd_q <= '0;
         end
         assign rd_data = rd_q;
      end
   endgenerate
endmodule

// File: rtl/snap_ctl_reg.sv
module snap_ctl_reg #(
   parameter int DATA_W    = 64,
   parameter int REQ_BIT   = 0,
   parameter int NOCAP_BIT = 32,
   parameter int RD_LAT    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              cap_req,
   input  logic              cap_done,
   input  logic              cap_fail
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("snap_ctl_reg: DATA_W too small");
      end
      if (REQ_BIT >= DATA_W || NOCAP_BIT >= DATA_W || REQ_BIT == NOCAP_BIT) begin : g_bad_pos
         $error("snap_ctl_reg: bad field positions");
      end
      if (RD_LAT != 0 && RD_LAT != 1) begin : g_bad_lat
         $error("snap_ctl_reg: RD_LAT must be 0 or 1");
      end
   endgenerate

   logic busy_q, nocap_q, trig_wr;
   snap_pkg::snap_state_t st;

   assign trig_wr = wr_en && wr_data[REQ_BIT];
   assign st      = '{busy: busy_q, nocap: nocap_q};

   snap_req_ctl u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_wr (trig_wr),
      .cap_done(cap_done),
      .busy_q  (busy_q),
      .req_q   (cap_req)
   );

   snap_status u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy_q  (busy_q),
      .cap_done(cap_done),
      .cap_fail(cap_fail),
      .nocap_q (nocap_q)
   );

   snap_rd_mux #(
      .DATA_W   (DATA_W),
      .REQ_BIT  (REQ_BIT),
      .NOCAP_BIT(NOCAP_BIT),
      .RD_LAT   (RD_LAT)
   ) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (rd_en),
      .st     (st),
      .rd_data(rd_data)
   );
endmodule

// File: rtl/snap_ctl_chk.sv
module snap_ctl_chk #(
   parameter int DATA_W    = 64,
   parameter int REQ_BIT   = 0,
   parameter int NOCAP_BIT = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              cap_req,
   input logic              cap_done,
   input logic              cap_fail,
   input logic              busy_q,
   input logic              nocap_q
);
   logic [DATA_W-1:0] mask;
   always_comb begin
      mask            = '0;
      mask[REQ_BIT]   = 1'b1;
      mask[NOCAP_BIT] = 1'b1;
   end

   a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[REQ_BIT] && !busy_q) |=> (cap_req && busy_q));
   a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
      cap_req |=> !cap_req);
   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !(wr_en && wr_data[REQ_BIT])) |=> (!busy_q && !cap_req));
   a_r4_no_pulse_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> !cap_req);
   a_r5_complete: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cap_done) |=> (!busy_q && nocap_q == $past(cap_fail)));
   a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |=> $stable(nocap_q));
   a_r7_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~mask) == '0);
endmodule

bind snap_ctl_reg snap_ctl_chk #(
   .DATA_W(DATA_W), .REQ_BIT(REQ_BIT), .NOCAP_BIT(NOCAP_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .rd_data(rd_data), .cap_req(cap_req), .cap_done(cap_done),
   .cap_fail(cap_fail), .busy_q(busy_q), .nocap_q(nocap_q)
);

// File: tb/test_snap_ctl_reg.sv
module test_snap_ctl_reg;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [63:0] rd_data;
   logic        cap_req;
   logic        cap_done = 1'b0;
   logic        cap_fail = 1'b0;

   int total = 0;
   int bad = 0;
   bit m_busy, m_nc;
   bit done_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   snap_ctl_reg i_snap_ctl_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .cap_req(cap_req),
      .cap_done(cap_done), .cap_fail(cap_fail)
   );

   function automatic logic [63:0] exp_word(bit b, bit n);
      logic [63:0] w = '0;
      w[0]  = b;
      w[32] = n;
      return w;
   endfunction

   function automatic string tag_of(bit we, logic [63:0] wd, bit dn, bit busy);
      if (busy && dn)        return "R5";
      if (!busy && dn)       return "R6";
      if (we && wd[0] && busy) return "R4";
      if (we && wd[0])       return "R2";
      if (we)                return "R3";
      return "R7";
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one cycle of stimulus, update the model, then check after the edge
   task automatic step(bit we, logic [63:0] wd, bit dn, bit fl, bit rd);
      bit exp_pulse;
      string tag;
      tag = tag_of(we, wd, dn, m_busy);
      wr_en = we; wr_data = wd; cap_done = dn; cap_fail = fl; rd_en = 1'b1;
      exp_pulse = !m_busy && we && wd[0];
      if (m_busy && dn) begin
         m_busy = 0; m_nc = fl;
      end else if (exp_pulse) begin
         m_busy = 1;
      end
      @(posedge clk);
      @(negedge clk);
      wr_en = 0; cap_done = 0; rd_en = rd;
      #1;
      check({tag, " pulse"}, {63'd0, cap_req}, {63'd0, exp_pulse});
      if (rd) check({tag, " read R8"}, rd_data, exp_word(m_busy, m_nc));
      else    check("R8 rd_en low", rd_data, 64'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed_1234));
      m_busy = 0; m_nc = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd_en = 1'b1;
      #1;
      // R1 reset state
      check("R1 reset word", rd_data, exp_word(0, 1));
      check("R1 reset pulse", {63'd0, cap_req}, 64'd0);
      // R3 write zero while idle
      step(1, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 1);
      // R2 trigger, R4 retrigger while busy, R7 all-ones write
      step(1, 64'h1, 0, 0, 1);
      step(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1);
      // R3 write zero while busy does not clear busy
      step(1, 64'h0, 0, 0, 1);
      // R5 done with success
      step(0, 64'h0, 1, 0, 1);
      // R6 stray done while idle keeps nocap
      step(0, 64'h0, 1, 1, 1);
      // R7 write to bit 32 only is ignored
      step(1, 64'h1_0000_0000, 0, 0, 1);
      // R4 write and done in same cycle while busy: ends idle, no pulse
      step(1, 64'h1, 0, 0, 1);
      step(1, 64'h1, 1, 1, 1);
      step(0, 64'h0, 0, 0, 1);
      // R8 read strobe low returns zero
      step(0, 64'h0, 0, 0, 0);
      // Random mix
      for (int i = 0; i < 3000; i++) begin
         bit we, dn, fl, rd;
         logic [63:0] wd;
         we = ($urandom % 3) == 0;
         dn = ($urandom % 4) == 0;
         fl = $urandom % 2;
         rd = ($urandom % 8) != 0;
         wd = {$urandom, $urandom};
         step(we, wd, dn, fl, rd);
      end
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule